// File: doc/BRIEF.md
# Address-Masked GPIO Data Port

This block is an eight-pin general-purpose I/O port on a simple single-cycle register bus with byte-wide data. Each pin has a direction bit and an output value bit. The block drives a pad output-enable and a pad output value for every pin. Pad inputs reach the block through a two-flop synchronizer.

The data register is not at a single address. It is reached through a window of 256 words. The low eight bits of the word address act as a per-pin mask: a write changes only the pins whose mask bit is 1, and a read shows only those pins. Software can therefore set or clear one pin with a single store, without reading the register first. A write to a pin has effect only while that pin is configured as an output.

The bus carries word addresses. The byte offset divided by four gives the word address: byte offset 0x400 is word 0x100.

Top module: `gpio_mask_port`

## Requirements
- R1: Out of reset, `padOe`, `padOut` and `busRdata` are all 0.
- R2: A write to word 0x100 (the direction register) loads all eight direction bits from `busWdata`, and they appear on `padOe` after that clock edge. A 1 bit makes the pin an output.
- R3: A write to word address A below 0x100 updates `padOut[n]` from `busWdata[n]` only where `A[n]` is 1 and pin n is an output. All other output bits hold their value.
- R4: A data-window write to a pin whose direction bit is 0 leaves `padOut` for that pin unchanged, even when the mask bit for that pin is 1.
- R5: A read of word address A below 0x100 returns, on the cycle after the request, each pin's level ANDed with `A[7:0]`. Masked-off bits read 0.
- R6: An input pin reads the pad level after two synchronizer flops. Consider a pad change applied between two clock edges. A read request sampled at the first or second edge after the change returns the old level. A request sampled at the third edge returns the new level.
- R7: An output pin reads back its driven `padOut` value, whatever the level on its pad.
- R8: A read of word 0x100 returns the direction register on the next cycle.
- R9: Accesses to any word at or above 0x101 are ignored. Writes change neither `padOe` nor `padOut`, and reads return 0.
- R10: While `busSel` is 0, no state changes and `busRdata` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Access request this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busWordAddr | input | 10 | Word address of the access |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, registered one cycle after the request |
| padIn | input | 8 | Asynchronous pad input levels |
| padOe | output | 8 | Per-pin output enable (direction) |
| padOut | output | 8 | Per-pin driven output value |

## Verification
The case hardest to reach is one where a single masked write covers a mix of pins: some masked-in and configured as outputs, some masked-in but configured as inputs, and some masked out. All three groups must behave differently in the same cycle. The random stimulus draws the direction register, the mask and the data independently, so every mix occurs many times. Directed sequences add two further checks: they pin down the exact read latency of a pad change through the synchronizer, and they show that an output pin ignores a conflicting pad level.

// File: rtl/gmp_pkg.sv
package gmp_pkg;
  typedef struct packed {
    logic dataWr;
    logic dirWr;
    logic dataRd;
    logic dirRd;
    logic otherRd;
  } gmpStrobe_t;
endpackage

// File: rtl/gmp_ctrl.sv
module gmp_ctrl
  import gmp_pkg::*;
#(
  parameter int PIN_COUNT = 8,
  parameter int WORD_W    = 10,
  parameter int DIR_WORD  = 256
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busSel,
  input  logic                 busWrite,
  input  logic [WORD_W-1:0]    busWordAddr,
  output gmpStrobe_t           strobe,
  output logic [PIN_COUNT-1:0] accMask
);
  localparam int WIN_WORDS = 1 << PIN_COUNT;
  localparam logic [WORD_W-1:0] WIN_LIMIT = WORD_W'(WIN_WORDS);
  localparam logic [WORD_W-1:0] DIR_ADDR  = WORD_W'(DIR_WORD);

  logic inWindow;
  logic atDir;

  assign inWindow = busWordAddr < WIN_LIMIT;
  assign atDir    = busWordAddr == DIR_ADDR;
  assign accMask  = busWordAddr[PIN_COUNT-1:0];

  always_comb begin
    strobe         = '0;
    strobe.dataWr  = busSel &  busWrite & inWindow;
    strobe.dirWr   = busSel &  busWrite & atDir;
    strobe.dataRd  = busSel & ~busWrite & inWindow;
    strobe.dirRd   = busSel & ~busWrite & atDir;
    strobe.otherRd = busSel & ~busWrite & ~inWindow & ~atDir;
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.dataWr, strobe.dirWr, strobe.dataRd, strobe.dirRd, strobe.otherRd})); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busSel |-> (strobe == '0)); // R10
endmodule

// File: rtl/gmp_datapath.sv
module gmp_datapath
  import gmp_pkg::*;
#(
  parameter int PIN_COUNT   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  gmpStrobe_t           strobe,
  input  logic [PIN_COUNT-1:0] accMask,
  input  logic [PIN_COUNT-1:0] wrData,
  input  logic [PIN_COUNT-1:0] padIn,
  output logic [PIN_COUNT-1:0] padOe,
  output logic [PIN_COUNT-1:0] padOut,
  output logic [PIN_COUNT-1:0] rdData
);
  logic [PIN_COUNT-1:0] dirReg;
  logic [PIN_COUNT-1:0] outReg;
  logic [PIN_COUNT-1:0] rdReg;
  logic [PIN_COUNT-1:0] syncStage [SYNC_STAGES];
  logic [PIN_COUNT-1:0] padSync;
  logic [PIN_COUNT-1:0] pinLevel;
  logic [PIN_COUNT-1:0] pinWrEn;

  genvar s;
  generate
    for (s = 0; s < SYNC_STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rstN) syncStage[s] <= '0;
          else       syncStage[s] <= padIn;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rstN) syncStage[s] <= '0;
          else       syncStage[s] <= syncStage[s-1];
        end
      end
    end
  endgenerate

  assign padSync  = syncStage[SYNC_STAGES-1];
  assign pinLevel = (dirReg & outReg) | (~dirReg & padSync);
  assign pinWrEn  = {PIN_COUNT{strobe.dataWr}} & accMask & dirReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dirReg <= '0;
    end else if (strobe.dirWr) begin
      dirReg <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outReg <= '0;
    end else begin
      outReg <= (pinWrEn & wrData) | (~pinWrEn & outReg);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdReg <= '0;
    end else if (strobe.dataRd) begin
      rdReg <= pinLevel & accMask;
    end else if (strobe.dirRd) begin
      rdReg <= dirReg;
    end else if (strobe.otherRd) begin
      rdReg <= '0;
    end
  end

  assign padOe  = dirReg;
  assign padOut = outReg;
  assign rdData = rdReg;

  AST_DIR_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strobe.dirWr |=> (padOe == $past(wrData))); // R2
  AST_UNMASKED_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    strobe.dataWr |=> (((padOut ^ $past(padOut)) & ~$past(accMask)) == '0)); // R3
  AST_INPUT_PIN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    strobe.dataWr |=> (((padOut ^ $past(padOut)) & ~$past(padOe)) == '0)); // R4
  AST_RD_MASKED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    strobe.dataRd |=> ((rdData & ~$past(accMask)) == '0)); // R5
  AST_OUT_NO_WR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.dataWr |=> $stable(padOut)); // R9
  AST_RD_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.dataRd | strobe.dirRd | strobe.otherRd) |=> $stable(rdData)); // R10
endmodule

// File: rtl/gpio_mask_port.sv
module gpio_mask_port
  import gmp_pkg::*;
#(
  parameter int PIN_COUNT   = 8,
  parameter int WORD_W      = 10,
  parameter int DIR_WORD    = 256,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busSel,
  input  logic                 busWrite,
  input  logic [WORD_W-1:0]    busWordAddr,
  input  logic [PIN_COUNT-1:0] busWdata,
  output logic [PIN_COUNT-1:0] busRdata,
  input  logic [PIN_COUNT-1:0] padIn,
  output logic [PIN_COUNT-1:0] padOe,
  output logic [PIN_COUNT-1:0] padOut
);
  gmpStrobe_t           strobe;
  logic [PIN_COUNT-1:0] accMask;

  gmp_ctrl #(
    .PIN_COUNT (PIN_COUNT),
    .WORD_W    (WORD_W),
    .DIR_WORD  (DIR_WORD)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .busSel      (busSel),
    .busWrite    (busWrite),
    .busWordAddr (busWordAddr),
    .strobe      (strobe),
    .accMask     (accMask)
  );

  gmp_datapath #(
    .PIN_COUNT   (PIN_COUNT),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .accMask (accMask),
    .wrData  (busWdata),
    .padIn   (padIn),
    .padOe   (padOe),
    .padOut  (padOut),
    .rdData  (busRdata)
  );
endmodule

// File: tb/gpio_mask_port_tb.sv
`timescale 1ns/1ps
module gpio_mask_port_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busSel = 1'b0;
  logic       busWrite = 1'b0;
  logic [9:0] busWordAddr = '0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic [7:0] padIn = '0;
  logic [7:0] padOe;
  logic [7:0] padOut;

  int vecCount = 0;
  int missCount = 0;
  bit finished = 1'b0;

  logic [7:0] mDir = '0;
  logic [7:0] mOut = '0;

  always #4 clk = ~clk;

  gpio_mask_port u_dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busWordAddr(busWordAddr), .busWdata(busWdata), .busRdata(busRdata),
    .padIn(padIn), .padOe(padOe), .padOut(padOut)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    vecCount++;
    if (act !== exp) begin
      missCount++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pinView(input logic [7:0] pad);
    return (mDir & mOut) | (~mDir & pad);
  endfunction

  function automatic logic [7:0] expRead(input logic [9:0] wa);
    if (wa < 10'h100) return pinView(padIn) & wa[7:0];
    if (wa == 10'h100) return mDir;
    return 8'h00;
  endfunction

  function automatic void modelWrite(input logic [9:0] wa, input logic [7:0] d);
    logic [7:0] en;
    if (wa == 10'h100) mDir = d;
    else if (wa < 10'h100) begin
      en = wa[7:0] & mDir;
      mOut = (en & d) | (~en & mOut);
    end
  endfunction

  task automatic busWr(input logic [9:0] wa, input logic [7:0] d);
    busSel = 1'b1; busWrite = 1'b1; busWordAddr = wa; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0;
    modelWrite(wa, d);
  endtask

  task automatic busRd(input logic [9:0] wa, output logic [7:0] d);
    busSel = 1'b1; busWrite = 1'b0; busWordAddr = wa;
    @(negedge clk);
    busSel = 1'b0;
    d = busRdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic checkPads(input string req);
    check({req, " padOe"}, padOe, mDir);
    check({req, " padOut"}, padOut, mOut);
  endtask

  function automatic logic [9:0] strayAddr();
    return 10'h101 + 10'($urandom % 767);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      missCount++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vecCount, missCount);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    logic [7:0] prevRd;
    logic [9:0] wa;
    logic [7:0] d;
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 padOe", padOe, 8'h00);
    check("R1 padOut", padOut, 8'h00);
    check("R1 busRdata", busRdata, 8'h00);
    rstN = 1'b1;
    @(negedge clk);

    // R4 write while all pins are inputs
    busWr(10'h0FF, 8'hFF);
    checkPads("R4");
    // R2 direction write
    busWr(10'h100, 8'h0F);
    checkPads("R2");
    busRd(10'h100, rd);
    check("R8 dir read", rd, 8'h0F);
    // R3 single pin write at mask bit 2
    busWr(10'h004, 8'hFF);
    checkPads("R3 single pin");
    check("R3 padOut", padOut, 8'h04);
    // R3/R4 mixed mask: outputs 0..3, inputs 4..7
    busWr(10'h0AA, 8'hFF);
    checkPads("R3 mixed");
    // R7 output pin ignores pad
    padIn = 8'hF0; idle(3);
    busRd(10'h0FF, rd);
    check("R7 readback", rd, expRead(10'h0FF));
    padIn = 8'h0F; idle(3);
    busRd(10'h0FF, rd);
    check("R7 readback pad inverted", rd, expRead(10'h0FF));
    // R5 masked read
    busRd(10'h0C3, rd);
    check("R5 masked read", rd, expRead(10'h0C3));
    busRd(10'h000, rd);
    check("R5 empty mask", rd, 8'h00);

    // R6 synchronizer latency on input pins
    busWr(10'h100, 8'h00);
    padIn = 8'h00; idle(3);
    padIn = 8'hA5;
    busRd(10'h0FF, rd);
    check("R6 first edge", rd, 8'h00);
    busRd(10'h0FF, rd);
    check("R6 second edge", rd, 8'h00);
    busRd(10'h0FF, rd);
    check("R6 third edge", rd, 8'hA5);

    // R9 stray addresses
    busWr(10'h100, 8'hFF);
    busWr(10'h0FF, 8'h5A);
    busWr(10'h101, 8'h00);
    checkPads("R9 write 0x101");
    busWr(10'h3FF, 8'h00);
    checkPads("R9 write 0x3FF");
    busRd(10'h200, rd);
    check("R9 stray read", rd, 8'h00);

    // R10 idle bus with active-looking inputs
    busRd(10'h100, prevRd);
    busWrite = 1'b1; busWordAddr = 10'h0FF; busWdata = 8'h00;
    idle(2);
    busWordAddr = 10'h100; idle(1);
    busWrite = 1'b0;
    checkPads("R10");
    check("R10 busRdata hold", busRdata, prevRd);

    // random mix
    for (int it = 0; it < 2000; it++) begin
      case ($urandom % 7)
        0: begin d = 8'($urandom); busWr(10'h100, d); checkPads("R2 rand"); end
        1, 2: begin
          wa = 10'($urandom % 256); d = 8'($urandom);
          busWr(wa, d); checkPads("R3 R4 rand");
        end
        3: begin
          wa = 10'($urandom % 256);
          busRd(wa, rd); check("R5 R7 rand read", rd, expRead(wa));
        end
        4: begin busRd(10'h100, rd); check("R8 rand", rd, mDir); end
        5: begin
          wa = strayAddr();
          if ($urandom % 2 == 0) begin
            busWr(wa, 8'($urandom)); checkPads("R9 rand wr");
          end else begin
            busRd(wa, rd); check("R9 rand rd", rd, 8'h00);
          end
        end
        default: begin padIn = 8'($urandom); idle(3); end
      endcase
    end

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end
endmodule